// File: doc/BRIEF.md
# Status register write controller

This block owns the processor's current status word and one saved status word for each exception mode. It applies move-to-status writes and serves move-from-status reads. A write can replace the whole word or only the condition flags. It can target the current word or the saved word of the active mode. Its operand is either a register value or an immediate. The block enforces the access rules of user and privileged modes, and it keeps the reserved bits fixed.

The exception controller sends an entry strobe together with the mode being entered. On that strobe the block banks the current word into that mode's saved copy and switches mode with the right interrupt masks. A return strobe copies the active mode's saved copy back into the current word.

Every input is a single-cycle strobe or level, sampled on the rising clock edge. No request is ever stalled, and no request ever stalls the block. Because no data stream passes through, the block has no valid/ready handshake and no back-pressure. Updates appear on `cpsr_o` one cycle after the request. `rd_data` is a combinational view of the current state.

Top module: `psr_ctrl`

## Requirements
- R1: After reset, the current word reads 0x000000D3 (supervisor mode 10011, I=1, F=1, flags clear). Every saved copy reads 0.
- R2: In user mode (mode field 10000), a write to the current word changes only the flags in bits 31:28, even when a whole-register write is requested.
- R3: In any other mode, a whole-register write to the current word updates bits 31:28 and 7:0 from the operand. These are the flags, I (bit 7), F (bit 6), T (bit 5) and the mode field (bits 4:0).
- R4: A flags-only write changes only bits 31:28, in every mode and for either target. With an immediate operand, the flags take the top four bits of the 32-bit immediate.
- R5: The operand is `wr_imm` when `wr_use_imm`=1, and `wr_reg` otherwise.
- R6: Bits 27:8 of the current word and of every saved copy never change from 0.
- R7: In the exception modes, a write with `wr_spsr`=1 updates that mode's saved copy under the privileged masks. The exception modes are FIQ 10001, IRQ 10010, supervisor 10011, abort 10111 and undefined 11011. In user mode or system mode (11111), such a write has no effect and a saved read returns 0.
- R8: `rd_data` returns the current word when `rd_spsr`=0. It returns the active mode's saved copy when `rd_spsr`=1.
- R9: An entry strobe whose `exc_mode` is an exception mode does four things. It copies the current word into that mode's saved copy and sets the mode field to `exc_mode`. It sets I, and it sets F when the target is FIQ. All other bits keep their values. An entry strobe with any other `exc_mode` has no effect.
- R10: A return strobe copies the active mode's saved copy into the current word. In user or system mode it leaves the current word unchanged.
- R11: Priority is entry first, then return, then write. A write that arrives in the same cycle as a return or an accepted entry is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Move-to-status request |
| wr_spsr | input | 1 | Write target: 1 selects the saved copy, 0 the current word |
| wr_flags_only | input | 1 | Restrict the write to bits 31:28 |
| wr_use_imm | input | 1 | Take the operand from wr_imm |
| wr_reg | input | 32 | Register operand |
| wr_imm | input | 32 | Immediate operand |
| rd_spsr | input | 1 | Read select: 1 selects the saved copy |
| rd_data | output | 32 | Move-from-status read data |
| exc_enter | input | 1 | Exception entry strobe |
| exc_mode | input | 5 | Mode being entered |
| exc_return | input | 1 | Return-from-exception strobe |
| cpsr_o | output | 32 | Current status word |

## Verification
The assertions check several properties on every cycle. The reserved field of the current word stays at zero. A user-mode write or a flags-only write leaves the control byte untouched. An accepted entry always sets I and loads the requested mode. A return strobe in user mode changes nothing, and a saved read in user or system mode returns zero. Other behaviour can only be shown by the bench's scenarios against its model: the exact merged values, the banking of each mode's saved copy, and the entry/return/write priority ordering.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W       = 32;
  localparam int MODE_W      = 5;
  localparam int NUM_BANKS   = 5;
  localparam int BANK_IDX_W  = $clog2(NUM_BANKS);
  localparam int IRQ_OFF_BIT = 7;
  localparam int FIQ_OFF_BIT = 6;

  localparam logic [PSR_W-1:0] FLAG_MASK = 32'hF000_0000;
  localparam logic [PSR_W-1:0] CTRL_MASK = 32'h0000_00FF;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  typedef struct packed {
    logic                  hit;
    logic [BANK_IDX_W-1:0] idx;
  } bank_sel_t;

  // Maps a mode to its saved-copy slot; hit=0 for modes without one.
  function automatic bank_sel_t bank_of(input logic [MODE_W-1:0] m);
    bank_sel_t s;
    s.hit = 1'b1;
    s.idx = '0;
    case (m)
      MODE_FIQ: s.idx = BANK_IDX_W'(0);
      MODE_IRQ: s.idx = BANK_IDX_W'(1);
      MODE_SVC: s.idx = BANK_IDX_W'(2);
      MODE_ABT: s.idx = BANK_IDX_W'(3);
      MODE_UND: s.idx = BANK_IDX_W'(4);
      default:  s.hit = 1'b0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/psr_merge.sv
module psr_merge
  import psr_pkg::*;
(
  input  logic [PSR_W-1:0] old_val,
  input  logic [PSR_W-1:0] operand,
  input  logic             ctrl_ok,
  input  logic             flags_only,
  output logic [PSR_W-1:0] new_val
);
  logic [PSR_W-1:0] mask;

  always_comb begin
    mask = FLAG_MASK;
    if (ctrl_ok && !flags_only) mask = FLAG_MASK | CTRL_MASK;
    new_val = (old_val & ~mask) | (operand & mask);
  end
endmodule

// File: rtl/psr_bank.sv
module psr_bank
  import psr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [BANK_IDX_W-1:0] wr_idx,
  input  logic [PSR_W-1:0]      wr_data,
  input  logic [BANK_IDX_W-1:0] rd_idx,
  output logic [PSR_W-1:0]      rd_data
);
  logic [PSR_W-1:0] slot_q [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q[g] <= '0;
      else if (wr_en && (wr_idx == BANK_IDX_W'(g)))
        slot_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_BANKS; i++)
      if (rd_idx == BANK_IDX_W'(i)) rd_data = slot_q[i];
  end
endmodule

// File: rtl/psr_ctrl.sv
module psr_ctrl
  import psr_pkg::*;
#(
  parameter logic [MODE_W-1:0] RESET_MODE = MODE_SVC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_spsr,
  input  logic              wr_flags_only,
  input  logic              wr_use_imm,
  input  logic [PSR_W-1:0]  wr_reg,
  input  logic [PSR_W-1:0]  wr_imm,
  input  logic              rd_spsr,
  output logic [PSR_W-1:0]  rd_data,
  input  logic              exc_enter,
  input  logic [MODE_W-1:0] exc_mode,
  input  logic              exc_return,
  output logic [PSR_W-1:0]  cpsr_o
);
  localparam logic [PSR_W-1:0] RESET_WORD =
    {24'h0, 1'b1, 1'b1, 1'b0, RESET_MODE};

  logic [PSR_W-1:0] cpsr_q, cpsr_d;
  logic [PSR_W-1:0] operand, cur_merged, sav_merged, sav_rd;
  logic             priv, entry_ok;
  bank_sel_t        act_sel, ent_sel;
  logic                  bank_we;
  logic [BANK_IDX_W-1:0] bank_widx;
  logic [PSR_W-1:0]      bank_wdata;

  assign priv     = cpsr_q[MODE_W-1:0] != MODE_USR;
  assign act_sel  = bank_of(cpsr_q[MODE_W-1:0]);
  assign ent_sel  = bank_of(exc_mode);
  assign entry_ok = exc_enter && ent_sel.hit;
  assign operand  = wr_use_imm ? wr_imm : wr_reg;

  psr_merge u_cur_merge (
    .old_val(cpsr_q), .operand(operand), .ctrl_ok(priv),
    .flags_only(wr_flags_only), .new_val(cur_merged)
  );

  psr_merge u_sav_merge (
    .old_val(sav_rd), .operand(operand), .ctrl_ok(1'b1),
    .flags_only(wr_flags_only), .new_val(sav_merged)
  );

  always_comb begin
    bank_we    = 1'b0;
    bank_widx  = act_sel.idx;
    bank_wdata = sav_merged;
    if (entry_ok) begin
      bank_we    = 1'b1;
      bank_widx  = ent_sel.idx;
      bank_wdata = cpsr_q;
    end else if (!exc_return && wr_en && wr_spsr && act_sel.hit) begin
      bank_we = 1'b1;
    end
  end

  psr_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(bank_we), .wr_idx(bank_widx),
    .wr_data(bank_wdata), .rd_idx(act_sel.idx), .rd_data(sav_rd)
  );

  always_comb begin
    cpsr_d = cpsr_q;
    if (entry_ok) begin
      cpsr_d[MODE_W-1:0]  = exc_mode;
      cpsr_d[IRQ_OFF_BIT] = 1'b1;
      if (exc_mode == MODE_FIQ) cpsr_d[FIQ_OFF_BIT] = 1'b1;
    end else if (exc_return) begin
      if (act_sel.hit) cpsr_d = sav_rd;
    end else if (wr_en && !wr_spsr) begin
      cpsr_d = cur_merged;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cpsr_q <= RESET_WORD;
    else        cpsr_q <= cpsr_d;
  end

  assign cpsr_o  = cpsr_q;
  assign rd_data = rd_spsr ? (act_sel.hit ? sav_rd : '0) : cpsr_q;
endmodule

// File: rtl/psr_ctrl_chk.sv
module psr_ctrl_chk
  import psr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_spsr,
  input logic              wr_flags_only,
  input logic              rd_spsr,
  input logic [PSR_W-1:0]  rd_data,
  input logic              exc_enter,
  input logic [MODE_W-1:0] exc_mode,
  input logic              exc_return,
  input logic [PSR_W-1:0]  cpsr_o
);
  logic in_user, no_bank, ent_hit;
  assign in_user = cpsr_o[MODE_W-1:0] == MODE_USR;
  assign no_bank = in_user || (cpsr_o[MODE_W-1:0] == MODE_SYS);
  assign ent_hit = bank_of(exc_mode).hit;

  // R6
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpsr_o[27:8] == 20'h0);

  // R2
  user_ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_user && wr_en && !wr_spsr && !exc_enter && !exc_return)
      |=> cpsr_o[7:0] == $past(cpsr_o[7:0]));

  // R4
  flags_only_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_spsr && wr_flags_only && !exc_enter && !exc_return)
      |=> cpsr_o[27:0] == $past(cpsr_o[27:0]));

  // R9
  entry_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_enter && ent_hit)
      |=> (cpsr_o[IRQ_OFF_BIT] && cpsr_o[MODE_W-1:0] == $past(exc_mode)));

  // R10
  user_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && in_user && !exc_enter) |=> $stable(cpsr_o));

  // R7
  no_bank_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_spsr && no_bank) |-> rd_data == '0);
endmodule

bind psr_ctrl psr_ctrl_chk u_psr_ctrl_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_spsr(wr_spsr),
  .wr_flags_only(wr_flags_only), .rd_spsr(rd_spsr), .rd_data(rd_data),
  .exc_enter(exc_enter), .exc_mode(exc_mode), .exc_return(exc_return),
  .cpsr_o(cpsr_o)
);

// File: tb/psr_ctrl_bench.sv
`timescale 1ns/1ps
module psr_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 0, wr_spsr = 0, wr_flags_only = 0, wr_use_imm = 0;
  logic [31:0] wr_reg = 0, wr_imm = 0;
  logic        rd_spsr = 0;
  logic [31:0] rd_data, cpsr_o;
  logic        exc_enter = 0, exc_return = 0;
  logic [4:0]  exc_mode = 0;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] m_cpsr;
  logic [31:0] m_sav [5];

  always #5 clk = ~clk;

  psr_ctrl u_psr_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_spsr(wr_spsr),
    .wr_flags_only(wr_flags_only), .wr_use_imm(wr_use_imm), .wr_reg(wr_reg),
    .wr_imm(wr_imm), .rd_spsr(rd_spsr), .rd_data(rd_data),
    .exc_enter(exc_enter), .exc_mode(exc_mode), .exc_return(exc_return),
    .cpsr_o(cpsr_o)
  );

  function automatic int slot(input logic [4:0] m);
    case (m)
      5'b10001: return 0;
      5'b10010: return 1;
      5'b10011: return 2;
      5'b10111: return 3;
      5'b11011: return 4;
      default:  return -1;
    endcase
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] op,
                                        input logic full);
    logic [31:0] mk;
    mk = full ? 32'hF000_00FF : 32'hF000_0000;
    return (old & ~mk) | (op & mk);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FIL%s %s actual=%h expected=%h", "", req, act, exp);
    end
  endtask

  // Update the model from the driven inputs, then compare after the edge.
  task automatic step(input string req);
    logic [31:0] op, nc;
    int a, e;
    op = wr_use_imm ? wr_imm : wr_reg;
    a  = slot(m_cpsr[4:0]);
    e  = slot(exc_mode);
    nc = m_cpsr;
    if (exc_enter && e >= 0) begin
      m_sav[e] = m_cpsr;
      nc[4:0] = exc_mode;
      nc[7] = 1'b1;
      if (exc_mode == 5'b10001) nc[6] = 1'b1;
    end else if (exc_return) begin
      if (a >= 0) nc = m_sav[a];
    end else if (wr_en && wr_spsr) begin
      if (a >= 0) m_sav[a] = merge(m_sav[a], op, !wr_flags_only);
    end else if (wr_en) begin
      nc = merge(m_cpsr, op, !wr_flags_only && m_cpsr[4:0] != 5'b10000);
    end
    m_cpsr = nc;
    @(negedge clk);
    wr_en = 0; exc_enter = 0; exc_return = 0;
    rd_spsr = 0; #1;
    check({req, " cur R8"}, rd_data, m_cpsr);
    check({req, " out"}, cpsr_o, m_cpsr);
    rd_spsr = 1; #1;
    a = slot(m_cpsr[4:0]);
    check({req, " sav R8"}, rd_data, (a >= 0) ? m_sav[a] : 32'h0);
    rd_spsr = 0;
  endtask

  task automatic do_wr(input logic sp, input logic fo, input logic ui,
                       input logic [31:0] r, input logic [31:0] im, input string req);
    wr_en = 1; wr_spsr = sp; wr_flags_only = fo; wr_use_imm = ui;
    wr_reg = r; wr_imm = im;
    step(req);
  endtask

  task automatic do_ent(input logic [4:0] m, input string req);
    exc_enter = 1; exc_mode = m;
    step(req);
  endtask

  task automatic do_ret(input string req);
    exc_return = 1;
    step(req);
  endtask

  function automatic logic [4:0] pick_mode(input int k);
    case (k % 8)
      0: return 5'b10000;
      1: return 5'b10001;
      2: return 5'b10010;
      3: return 5'b10011;
      4: return 5'b10111;
      5: return 5'b11011;
      6: return 5'b11111;
      default: return 5'b00101;
    endcase
  endfunction

  initial begin : watchdog
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_cpsr = 32'h0000_00D3;
    for (int i = 0; i < 5; i++) m_sav[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 reset cur", cpsr_o, 32'h0000_00D3);
    rd_spsr = 1; #1;
    check("R1 reset sav", rd_data, 32'h0);
    rd_spsr = 0;

    // R3 / R6: privileged full write, reserved bits stay zero
    do_wr(0, 0, 0, 32'hA5FF_FF12, 32'h0, "R3 R6 full write");
    check("R3 value", cpsr_o, 32'hA000_0012);
    // R7: saved write in IRQ mode
    do_wr(1, 0, 0, 32'h5FFF_FF9F, 32'h0, "R7 sav write");
    // R4 / R5: flags-only immediate
    do_wr(0, 1, 1, 32'hFFFF_FFFF, 32'h3000_0000, "R4 R5 imm flags");
    check("R4 imm flags", cpsr_o, 32'h3000_0012);
    // R10: return copies the saved copy
    do_ret("R10 return");
    check("R10 value", cpsr_o, 32'h5000_009F);
    // to user mode, then R2
    do_wr(0, 0, 0, 32'h0000_0010, 32'h0, "R3 to user");
    do_wr(0, 0, 0, 32'hF000_001F, 32'h0, "R2 user full");
    check("R2 value", cpsr_o, 32'hF000_0010);
    do_wr(1, 0, 0, 32'hFFFF_FFFF, 32'h0, "R7 user sav ignored");
    do_ret("R10 user return ignored");
    check("R10 user", cpsr_o, 32'hF000_0010);
    // R9: entry to FIQ
    do_ent(5'b10001, "R9 fiq entry");
    check("R9 fiq", cpsr_o, 32'hF000_00D1);
    do_ent(5'b00111, "R9 bad mode ignored");
    // R11: entry beats write, return beats write
    wr_en = 1; wr_spsr = 0; wr_flags_only = 0; wr_use_imm = 0; wr_reg = 32'h0000_0013;
    do_ent(5'b10010, "R11 entry over write");
    wr_en = 1; wr_spsr = 1; wr_reg = 32'hFFFF_FFFF;
    do_ret("R11 return over write");
    check("R11 value", cpsr_o, 32'hF000_00D1);

    for (int it = 0; it < 3000; it++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 5)
        do_wr(1'($urandom), 1'($urandom), 1'($urandom),
              {$urandom, 3'b0, pick_mode(it)} | 32'($urandom_range(0, 7) << 5) & 32'hFFFF_FFFF,
              $urandom, "R2 R3 R4 R5 R6 R7 rand write");
      else if (op < 8) begin
        wr_en = 1'($urandom); wr_spsr = 1'($urandom); wr_reg = $urandom;
        do_ent(pick_mode(int'($urandom)), "R9 R11 rand entry");
      end else begin
        wr_en = 1'($urandom); wr_spsr = 1'($urandom); wr_reg = $urandom;
        do_ret("R10 R11 rand return");
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule